// File: doc/BRIEF.md
# Periodic Impedance Calibration Stepper

This block is the digital side of a self-trimming pad impedance. It keeps two
binary-weighted leg-select codes, one for the output driver and one for the
input termination. Each bit of a code switches in a parallel leg, so a larger
code gives a lower impedance. A free-running cycle timer raises a one-cycle
evaluation strobe once per period. On that strobe each code looks at its own
comparator verdict and moves by at most one count toward the target. Both codes
use the same timer, and the loop keeps running for as long as it is enabled, so
that it follows slow supply and temperature drift.

Each code has two comparator flags. `drv_imp_high` / `term_imp_high` say that
the present impedance is above target. `drv_in_band` / `term_in_band` say that
it is within the dead band. All four flags arrive asynchronously, and each passes
through a two-flop synchronizer before the block uses it. The block has no data
stream, so every pin is plain control or status. There is no valid/ready
handshake and no back-pressure.

Top module: `imp_cal_stepper`

## Requirements
- R1: While reset is asserted and right after it is released, both codes equal mid-scale (only the most significant bit set, 8 for a 4-bit code) and `eval_stb` is 0.
- R2: When `cal_en` is held high, `eval_stb` pulses for exactly one cycle. The first pulse comes PERIOD cycles after reset release, and later pulses follow every PERIOD cycles.
- R3: Suppose the synchronized flags of a code read "above target" (`*_imp_high`=1 and `*_in_band`=0) and the code is below all-ones. The code then rises by exactly one at the clock edge that ends the strobe cycle.
- R4: Suppose the synchronized flags read "below target" (`*_imp_high`=0 and `*_in_band`=0) and the code is above zero. The code then falls by exactly one at that same edge.
- R5: When the synchronized `*_in_band` flag is 1, the code keeps its value at an evaluation, whatever the value of `*_imp_high`.
- R6: A code saturates. It stays at all-ones when asked to rise, and it stays at zero when asked to fall. It never wraps.
- R7: Neither code changes at any clock edge other than the one that ends a strobe cycle.
- R8: The driver and termination codes are evaluated at the same edge, and each follows only its own pair of flags.
- R9: While `cal_en` is low, the cycle timer is held at zero, no new strobe is issued and both codes hold. After `cal_en` rises again, the first strobe comes PERIOD cycles later.
- R10: Each flag is used only after two synchronizer stages. A flag change made during the strobe cycle has no effect on that evaluation, and it takes effect at the next evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_en | input | 1 | Enables the period timer and the evaluations |
| drv_imp_high | input | 1 | Async: driver impedance above target |
| drv_in_band | input | 1 | Async: driver impedance within dead band |
| term_imp_high | input | 1 | Async: termination impedance above target |
| term_in_band | input | 1 | Async: termination impedance within dead band |
| drv_code | output | CODE_W | Driver leg-select code |
| term_code | output | CODE_W | Termination leg-select code |
| eval_stb | output | 1 | One-cycle evaluation strobe |

## Verification
The strobe is registered. With `cal_en` high from reset release, it is seen high at the falling edge after the PERIOD-th rising edge. A code moves one rising edge later, so the bench samples the codes at the falling edge after the one where it sees the strobe. A flag must be steady for two rising edges before the edge that ends the strobe cycle. The bench therefore changes flags well away from a strobe, except in the synchronizer test. That test changes a flag exactly at the strobe's falling edge and expects the old verdict to be used. Timing checks count falling edges from reset release or from re-enable up to the first strobe, and expect exactly PERIOD of them.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_t;

  // Above target => more legs (code up); below target => fewer legs.
  function automatic step_dir_t pick_step(input logic imp_high,
                                          input logic in_band);
    if (in_band)       return STEP_HOLD;
    else if (imp_high) return STEP_UP;
    else               return STEP_DOWN;
  endfunction

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_in;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic stb
);

  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stb_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= en && at_last;
      if (!en || at_last) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stb = stb_q;

  // R2: strobe never lasts more than one cycle
  p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R9: disabled timer issues no strobe
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stb_q);

  // R9: disabled timer returns to zero
  p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/cal_code_step.sv
module cal_code_step
  import imp_cal_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              imp_high,
  input  logic              in_band,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_MAX ^ (CODE_MAX >> 1);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nxt;
  step_dir_t         dir;

  always_comb begin
    dir      = pick_step(imp_high, in_band);
    code_nxt = code_q;
    if (upd) begin
      unique case (dir)
        STEP_UP:   if (code_q != CODE_MAX) code_nxt = code_q + 1'b1;
        STEP_DOWN: if (code_q != CODE_MIN) code_nxt = code_q - 1'b1;
        default:   code_nxt = code_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= CODE_MID;
    else        code_q <= code_nxt;
  end

  assign code = code_q;

  // R7: no evaluation, no movement
  p_hold_no_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(code_q));

  // R5: dead band freezes the code
  p_dead_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && in_band) |=> $stable(code_q));

  // R3: single step upward
  p_up_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && imp_high && !in_band && code_q != CODE_MAX)
      |=> (code_q == $past(code_q) + 1'b1));

  // R4: single step downward
  p_down_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !imp_high && !in_band && code_q != CODE_MIN)
      |=> (code_q == $past(code_q) - 1'b1));

  // R6: saturation at both ends
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && imp_high && !in_band && code_q == CODE_MAX) |=> (code_q == CODE_MAX));
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !imp_high && !in_band && code_q == CODE_MIN) |=> (code_q == CODE_MIN));

endmodule

// File: rtl/imp_cal_stepper.sv
module imp_cal_stepper #(
  parameter int CODE_W      = 6,
  parameter int PERIOD      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_en,
  input  logic              drv_imp_high,
  input  logic              drv_in_band,
  input  logic              term_imp_high,
  input  logic              term_in_band,
  output logic [CODE_W-1:0] drv_code,
  output logic [CODE_W-1:0] term_code,
  output logic              eval_stb
);

  localparam int N_CH   = 2;          // 0: driver, 1: termination
  localparam int FLAG_W = 2 * N_CH;   // {in_band, imp_high} per channel

  logic [FLAG_W-1:0] flags_raw;
  logic [FLAG_W-1:0] flags_s;
  logic              stb;
  logic [CODE_W-1:0] code_arr [N_CH];

  assign flags_raw = {term_in_band, term_imp_high, drv_in_band, drv_imp_high};

  cal_sync #(
    .WIDTH  (FLAG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (flags_raw),
    .sync_out (flags_s)
  );

  cal_timer #(
    .PERIOD (PERIOD)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cal_en),
    .stb   (stb)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      cal_code_step #(
        .CODE_W (CODE_W)
      ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (stb),
        .imp_high (flags_s[2*c]),
        .in_band  (flags_s[2*c+1]),
        .code     (code_arr[c])
      );
    end
  endgenerate

  assign drv_code  = code_arr[0];
  assign term_code = code_arr[1];
  assign eval_stb  = stb;

  // R8: both codes only ever move on the shared evaluation edge
  p_shared_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_code != $past(drv_code) || term_code != $past(term_code)) |-> $past(stb));

endmodule

// File: tb/imp_cal_stepper_tb.sv
module imp_cal_stepper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int P          = 16;
  localparam int MID        = 8;
  localparam int MAXC       = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cal_en = 1'b0;
  logic         drv_imp_high = 1'b0, drv_in_band = 1'b1;
  logic         term_imp_high = 1'b0, term_in_band = 1'b1;
  logic [W-1:0] drv_code, term_code;
  logic         eval_stb;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imp_cal_stepper #(.CODE_W(W), .PERIOD(P), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en),
    .drv_imp_high(drv_imp_high), .drv_in_band(drv_in_band),
    .term_imp_high(term_imp_high), .term_in_band(term_in_band),
    .drv_code(drv_code), .term_code(term_code), .eval_stb(eval_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns number of falling edges until eval_stb is seen high (0 on timeout).
  task automatic wait_stb(output int cycles);
    cycles = 0;
    for (int i = 1; i <= 4*P; i++) begin
      @(negedge clk);
      if (eval_stb) begin cycles = i; return; end
    end
  endtask

  // Wait for a strobe and move to the falling edge after the update.
  task automatic next_eval(input string req);
    int c;
    wait_stb(c);
    if (c == 0) chk({req, " strobe timeout"}, 0, 1);
    @(negedge clk);
  endtask

  task automatic set_flags(input logic dh, input logic db,
                           input logic th, input logic tb);
    drv_imp_high = dh; drv_in_band = db;
    term_imp_high = th; term_in_band = tb;
  endtask

  task automatic t_reset_and_period();
    int c;
    rst_n = 1'b0; cal_en = 1'b1;
    set_flags(1'b0, 1'b1, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R1 drv_code in reset", int'(drv_code), MID);
    chk("R1 term_code in reset", int'(term_code), MID);
    chk("R1 eval_stb in reset", int'(eval_stb), 0);
    rst_n = 1'b1;
    wait_stb(c);
    chk("R2 first strobe delay", c, P);
    chk("R1 drv_code mid before first eval", int'(drv_code), MID);
    @(negedge clk);
    chk("R2 strobe one cycle wide", int'(eval_stb), 0);
    chk("R5 dead band holds drv", int'(drv_code), MID);
    wait_stb(c);
    chk("R2 strobe period", c + 1, P);
  endtask

  task automatic t_step_up_and_down();
    @(negedge clk);
    set_flags(1'b1, 1'b0, 1'b0, 1'b1);
    next_eval("R3");
    chk("R3 drv step up", int'(drv_code), MID + 1);
    chk("R8 term untouched", int'(term_code), MID);
    set_flags(1'b0, 1'b0, 1'b1, 1'b0);
    next_eval("R4");
    chk("R4 drv step down", int'(drv_code), MID);
    chk("R8 term step up same edge", int'(term_code), MID + 1);
    set_flags(1'b1, 1'b1, 1'b0, 1'b1);
    next_eval("R5");
    chk("R5 in-band with high flag holds", int'(drv_code), MID);
  endtask

  task automatic t_stable_between();
    int d0, t0;
    set_flags(1'b1, 1'b0, 1'b0, 1'b0);
    next_eval("R7");
    d0 = int'(drv_code); t0 = int'(term_code);
    for (int i = 0; i < P - 2; i++) begin
      @(negedge clk);
      if (eval_stb) break;
      chk("R7 drv stable between evals", int'(drv_code), d0);
      chk("R7 term stable between evals", int'(term_code), t0);
    end
  endtask

  task automatic t_saturate();
    set_flags(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < MAXC + 2; i++) next_eval("R6");
    chk("R6 drv saturates at all-ones", int'(drv_code), MAXC);
    chk("R6 term saturates at zero", int'(term_code), 0);
    next_eval("R6");
    chk("R6 drv no wrap", int'(drv_code), MAXC);
    chk("R6 term no wrap", int'(term_code), 0);
    set_flags(1'b0, 1'b0, 1'b1, 1'b0);
    next_eval("R6");
    chk("R6 drv leaves top by one", int'(drv_code), MAXC - 1);
    chk("R6 term leaves bottom by one", int'(term_code), 1);
  endtask

  task automatic t_enable();
    int c, seen, d0, t0;
    d0 = int'(drv_code); t0 = int'(term_code);
    cal_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 3*P; i++) begin
      @(negedge clk);
      if (eval_stb) seen++;
    end
    chk("R9 no strobe while disabled", seen, 0);
    chk("R9 drv held while disabled", int'(drv_code), d0);
    chk("R9 term held while disabled", int'(term_code), t0);
    cal_en = 1'b1;
    wait_stb(c);
    chk("R9 first strobe after re-enable", c, P);
    @(negedge clk);
    chk("R9 drv moves after re-enable", int'(drv_code), d0 - 1);
  endtask

  task automatic t_sync();
    int c, d0;
    set_flags(1'b0, 1'b1, 1'b0, 1'b1);
    next_eval("R10");
    d0 = int'(drv_code);
    wait_stb(c);
    set_flags(1'b1, 1'b0, 1'b0, 1'b1);   // changed during strobe cycle
    @(negedge clk);
    chk("R10 late flag change ignored", int'(drv_code), d0);
    next_eval("R10");
    chk("R10 flag used at next eval", int'(drv_code), d0 + 1);
  endtask

  initial begin
    t_reset_and_period();
    t_step_up_and_down();
    t_stable_between();
    t_saturate();
    t_enable();
    t_sync();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule